// File: doc/BRIEF.md
# TDM Time Slot Interchange Switch

This block is a non-blocking time slot interchanger for serial time-division streams. A set of serial input streams each carry a fixed number of byte-wide channels per frame. Every bit is held for `CLK_PER_BIT` clock cycles, and each byte is sent most significant bit first. The block turns each received byte into a parallel word and stores it in a banked data memory, indexed by input stream and channel. It then rebuilds the serial output streams from that memory.

A connection memory holds one entry per output channel. Each entry has a low word and a high word:

- **Low word:** the input stream and channel to route from, or a literal byte to send in message mode.
- **High word:** four control bits. These set drive enable, message mode, constant-delay routing, and the level of that channel's bit on the control bitstream.

A frame sync input restarts the frame timing. A global output-drive input can silence every serial output at once. The serial outputs are modelled as a data bit together with a drive-enable bit, and the drive-enable is what selects high impedance.

Top module: `tdm_slot_switch`

## Requirements
- R1: A high `fsync` at a clock edge starts a new frame in the next cycle. A frame has CHANS slots of BITS bit periods each, and a bit period lasts CLK_PER_BIT cycles. Inputs are sampled in the last cycle of each bit period. Output channel k of stream s is sent during slot k, most significant bit first.
- R2: Any input channel can be routed to any output channel. The low word gives the source address, with the input stream in bits [ADDR_W-1:CH_W] and the input channel in bits [CH_W-1:0]. Low-word bits above ADDR_W are ignored.
- R3: When high-word bit 2 is 0 (variable delay), the output byte depends on the source slot. If the source slot is earlier than the output slot, the output byte is the one received in the same frame. This includes the slot just before the output slot. Otherwise the output byte is the one received in the previous frame.
- R4: When high-word bit 2 is 1 (constant delay), the byte received in frame F is sent in frame F+2, for every pair of input and output slots.
- R5: When high-word bit 1 is 1 (message mode), the output channel sends the low byte of its low word in place of switched data.
- R6: When high-word bit 0 is 0, that output channel is not driven: its enable is 0 and its data bit reads 0.
- R7: When `ode` is 0, every serial output enable and data bit is 0, whatever the connection memory holds.
- R8: `ctl_o` carries one bit per bit period. During bit period b of slot k it equals high-word bit 3 of output channel (stream b, slot k). It is 0 when b is not below STREAMS.
- R9: After reset, the connection memory is all zero. As a result, all outputs and `ctl_o` are 0 and no channel is driven.
- R10: A write with `cm_we` high loads `cm_wdata` into entry `cm_addr`. `cm_addr` is {stream, slot}. The write goes to the high word when `cm_sel_hi` is 1 and to the low word otherwise. The new entry takes effect for the next slot that loads after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_PER_BIT cycles per bit period |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync; restarts frame timing |
| ode | input | 1 | Global output drive enable |
| sti | input | STREAMS | Serial input streams |
| sto | output | STREAMS | Serial output data bits |
| sto_oe | output | STREAMS | Per-stream drive enable (0 = high impedance) |
| ctl_o | output | 1 | Per-channel control bitstream |
| cm_we | input | 1 | Connection memory write strobe |
| cm_sel_hi | input | 1 | Selects the high word for the write |
| cm_addr | input | ADDR_W | Output channel address {stream, slot} |
| cm_wdata | input | LO_W | Write data |

## Verification
The bench builds the switch with four streams, eight slots, byte-wide channels and two cycles per bit. This gives a 128-cycle frame, so dozens of frames and several full reprogrammings of the connection memory fit into a short run. With only eight slots, random routes regularly land on the delicate cases: a source in the slot just before the output slot (the forwarding path), a source in the same slot, and a source in slot 0 or the last slot. With four streams, the control bitstream has bit periods that have no stream behind them, so those periods must read zero.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // High word of a connection entry: bit 3 control level, bit 2 constant
    // delay, bit 1 message mode, bit 0 drive enable.
    localparam int HI_W = 4;

    typedef struct packed {
        logic ctl;
        logic cdelay;
        logic msg;
        logic drive;
    } cm_hi_t;

    // Frame bank indices cycle through 0, 1, 2.
    function automatic logic [1:0] mod3_inc(input logic [1:0] v);
        return (v == 2'd2) ? 2'd0 : v + 2'd1;
    endfunction

    function automatic logic [1:0] mod3_dec(input logic [1:0] v);
        return (v == 2'd0) ? 2'd2 : v - 2'd1;
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing import tsi_pkg::*; #(
    parameter int CLK_PER_BIT = 2,
    parameter int BITS        = 8,
    parameter int CHANS       = 32,
    localparam int PH_W  = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1,
    localparam int BIT_W = $clog2(BITS),
    localparam int CH_W  = $clog2(CHANS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    output logic [CH_W-1:0]  ch_o,
    output logic [1:0]       fmod_o,
    output logic             bit_end_o,
    output logic             slot_end_o
);

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [BIT_W-1:0] bt;
        logic [CH_W-1:0]  ch;
        logic [1:0]       fm;
    } tm_t;

    tm_t  tm_q, tm_d;
    logic frame_end;

    assign bit_end_o  = (tm_q.ph == PH_W'(CLK_PER_BIT - 1));
    assign slot_end_o = bit_end_o && (tm_q.bt == BIT_W'(BITS - 1));
    assign frame_end  = slot_end_o && (tm_q.ch == CH_W'(CHANS - 1));
    assign ch_o       = tm_q.ch;
    assign fmod_o     = tm_q.fm;

    always_comb begin
        tm_d = tm_q;
        if (fsync_i) begin
            tm_d.ph = '0;
            tm_d.bt = '0;
            tm_d.ch = '0;
            tm_d.fm = mod3_inc(tm_q.fm);
        end else begin
            tm_d.ph = bit_end_o ? '0 : tm_q.ph + PH_W'(1);
            if (bit_end_o)  tm_d.bt = slot_end_o ? '0 : tm_q.bt + BIT_W'(1);
            if (slot_end_o) tm_d.ch = frame_end ? '0 : tm_q.ch + CH_W'(1);
            if (frame_end)  tm_d.fm = mod3_inc(tm_q.fm);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> (tm_q.ph == '0 && tm_q.bt == '0 && tm_q.ch == '0)); // R1
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !fsync_i) |=> (tm_q.ch == '0 && tm_q.fm != $past(tm_q.fm))); // R1
    AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.fm != 2'd3); // R4

endmodule

// File: rtl/tsi_capture.sv
module tsi_capture #(
    parameter int STREAMS = 8,
    parameter int CHANS   = 32,
    parameter int BITS    = 8,
    localparam int ST_W   = $clog2(STREAMS),
    localparam int CH_W   = $clog2(CHANS),
    localparam int ADDR_W = ST_W + CH_W,
    localparam int DEPTH  = STREAMS * CHANS
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [STREAMS-1:0]              sti_i,
    input  logic                            bit_end_i,
    input  logic                            slot_end_i,
    input  logic [CH_W-1:0]                 ch_i,
    input  logic [1:0]                      fmod_i,
    input  logic [STREAMS-1:0][1:0]         rd_bank_i,
    input  logic [STREAMS-1:0][ADDR_W-1:0]  rd_addr_i,
    output logic [STREAMS-1:0][BITS-1:0]    rd_data_o,
    output logic [STREAMS-1:0][BITS-1:0]    byte_now_o
);

    typedef struct packed {
        logic [STREAMS-1:0][BITS-1:0] sh;
    } cap_t;

    cap_t            cap_q, cap_d;
    logic [BITS-1:0] mem_q [0:2][0:DEPTH-1];

    for (genvar s = 0; s < STREAMS; s++) begin : g_stream
        assign byte_now_o[s] = {cap_q.sh[s][BITS-2:0], sti_i[s]};
        assign rd_data_o[s]  = mem_q[rd_bank_i[s]][rd_addr_i[s]];
    end

    always_comb begin
        cap_d = cap_q;
        if (bit_end_i) begin
            for (int s = 0; s < STREAMS; s++) begin
                cap_d.sh[s] = byte_now_o[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // One bank per frame; all streams complete a byte on the same edge.
    always_ff @(posedge clk) begin
        if (slot_end_i) begin
            for (int s = 0; s < STREAMS; s++) begin
                mem_q[fmod_i][{ST_W'(s), ch_i}] <= byte_now_o[s];
            end
        end
    end

    AST_SAMPLE_ON_BIT_END: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end_i |=> (cap_q.sh[0][0] == $past(sti_i[0]))); // R1
    AST_HOLD_BETWEEN_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_end_i |=> $stable(cap_q.sh)); // R1

endmodule

// File: rtl/tsi_connmem.sv
module tsi_connmem import tsi_pkg::*; #(
    parameter int STREAMS = 8,
    parameter int CHANS   = 32,
    parameter int LO_W    = 8,
    localparam int ST_W   = $clog2(STREAMS),
    localparam int CH_W   = $clog2(CHANS),
    localparam int ADDR_W = ST_W + CH_W,
    localparam int DEPTH  = STREAMS * CHANS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic                          sel_hi_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [LO_W-1:0]               wdata_i,
    input  logic [CH_W-1:0]               rd_ch_i,
    output logic [STREAMS-1:0][LO_W-1:0]  lo_o,
    output cm_hi_t [STREAMS-1:0]          hi_o
);

    logic [LO_W-1:0] lo_q [0:DEPTH-1];
    cm_hi_t          hi_q [0:DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else if (we_i) begin
            if (sel_hi_i) hi_q[addr_i] <= cm_hi_t'(wdata_i[HI_W-1:0]);
            else          lo_q[addr_i] <= wdata_i;
        end
    end

    for (genvar s = 0; s < STREAMS; s++) begin : g_rd
        assign lo_o[s] = lo_q[{ST_W'(s), rd_ch_i}];
        assign hi_o[s] = hi_q[{ST_W'(s), rd_ch_i}];
    end

    AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !sel_hi_i) |=> (lo_q[$past(addr_i)] == $past(wdata_i))); // R10
    AST_HI_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_hi_i) |=> (hi_q[$past(addr_i)] == $past(wdata_i[HI_W-1:0]))); // R10

endmodule

// File: rtl/tsi_output.sv
module tsi_output import tsi_pkg::*; #(
    parameter int STREAMS = 8,
    parameter int CHANS   = 32,
    parameter int BITS    = 8,
    parameter int LO_W    = 8,
    localparam int ST_W   = $clog2(STREAMS),
    localparam int CH_W   = $clog2(CHANS),
    localparam int ADDR_W = ST_W + CH_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ode_i,
    input  logic                            bit_end_i,
    input  logic                            slot_end_i,
    input  logic [CH_W-1:0]                 ch_i,
    input  logic [1:0]                      fmod_i,
    input  logic [STREAMS-1:0][LO_W-1:0]    lo_i,
    input  cm_hi_t [STREAMS-1:0]            hi_i,
    input  logic [STREAMS-1:0][BITS-1:0]    byte_now_i,
    input  logic [STREAMS-1:0][BITS-1:0]    rd_data_i,
    output logic [STREAMS-1:0][1:0]         rd_bank_o,
    output logic [STREAMS-1:0][ADDR_W-1:0]  rd_addr_o,
    output logic [CH_W-1:0]                 k_next_o,
    output logic [STREAMS-1:0]              sto_o,
    output logic [STREAMS-1:0]              sto_oe_o,
    output logic                            ctl_o
);

    typedef struct packed {
        logic [STREAMS-1:0][BITS-1:0] oreg;
        logic [STREAMS-1:0]           oen;
        logic [BITS-1:0]              ctl;
    } ost_t;

    ost_t                         st_q, st_d;
    logic                         last_slot;
    logic [1:0]                   fo;
    logic [STREAMS-1:0][BITS-1:0] load_byte;
    logic [BITS-1:0]              ctl_load;

    // Loading happens in the last cycle of slot k-1 for slot k.
    assign last_slot = (ch_i == CH_W'(CHANS - 1));
    assign k_next_o  = last_slot ? '0 : ch_i + CH_W'(1);
    assign fo        = last_slot ? mod3_inc(fmod_i) : fmod_i;

    for (genvar s = 0; s < STREAMS; s++) begin : g_sel
        logic [CH_W-1:0] src_ch;
        logic [ST_W-1:0] src_st;
        logic            fwd;
        assign src_ch       = lo_i[s][CH_W-1:0];
        assign src_st       = lo_i[s][ADDR_W-1:CH_W];
        assign rd_addr_o[s] = lo_i[s][ADDR_W-1:0];
        // Source slot k-1 is completing on the load edge: forward it.
        assign fwd          = !hi_i[s].cdelay && (src_ch == ch_i);
        assign rd_bank_o[s] = hi_i[s].cdelay    ? mod3_inc(fo) :
                              (src_ch < k_next_o) ? fo : mod3_dec(fo);
        assign load_byte[s] = hi_i[s].msg ? lo_i[s][BITS-1:0] :
                              fwd         ? byte_now_i[src_st] : rd_data_i[s];
    end

    for (genvar b = 0; b < BITS; b++) begin : g_ctl
        if (b < STREAMS) begin : g_live
            assign ctl_load[b] = hi_i[b].ctl;
        end else begin : g_pad
            assign ctl_load[b] = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (slot_end_i) begin
            st_d.oreg = load_byte;
            for (int s = 0; s < STREAMS; s++) st_d.oen[s] = hi_i[s].drive;
            st_d.ctl = ctl_load;
        end else if (bit_end_i) begin
            for (int s = 0; s < STREAMS; s++) begin
                st_d.oreg[s] = {st_q.oreg[s][BITS-2:0], 1'b0};
            end
            st_d.ctl = st_q.ctl >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar s = 0; s < STREAMS; s++) begin : g_pin
        assign sto_oe_o[s] = ode_i & st_q.oen[s];
        assign sto_o[s]    = sto_oe_o[s] & st_q.oreg[s][BITS-1];
    end
    assign ctl_o = st_q.ctl[0];

    AST_MID_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_end_i |=> $stable(st_q)); // R1
    AST_MSB_FIRST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end_i && !slot_end_i) |=>
            (st_q.oreg[0] == {$past(st_q.oreg[0][BITS-2:0]), 1'b0})); // R1
    AST_MSG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end_i && hi_i[0].msg) |=> (st_q.oreg[0] == $past(lo_i[0][BITS-1:0]))); // R5
    AST_ODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ode_i |-> (sto_oe_o == '0 && sto_o == '0)); // R7
    AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sto_oe_o[0] |-> !sto_o[0]); // R6

endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch import tsi_pkg::*; #(
    parameter int STREAMS     = 8,
    parameter int CHANS       = 32,
    parameter int BITS        = 8,
    parameter int CLK_PER_BIT = 2,
    localparam int ST_W   = $clog2(STREAMS),
    localparam int CH_W   = $clog2(CHANS),
    localparam int ADDR_W = ST_W + CH_W,
    localparam int LO_W   = (BITS > ADDR_W) ? BITS : ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic               ode,
    input  logic [STREAMS-1:0] sti,
    output logic [STREAMS-1:0] sto,
    output logic [STREAMS-1:0] sto_oe,
    output logic               ctl_o,
    input  logic               cm_we,
    input  logic               cm_sel_hi,
    input  logic [ADDR_W-1:0]  cm_addr,
    input  logic [LO_W-1:0]    cm_wdata
);

    logic [CH_W-1:0]               ch;
    logic [CH_W-1:0]               k_next;
    logic [1:0]                    fmod;
    logic                          bit_end;
    logic                          slot_end;
    logic [STREAMS-1:0][1:0]       rd_bank;
    logic [STREAMS-1:0][ADDR_W-1:0] rd_addr;
    logic [STREAMS-1:0][BITS-1:0]  rd_data;
    logic [STREAMS-1:0][BITS-1:0]  byte_now;
    logic [STREAMS-1:0][LO_W-1:0]  cm_lo;
    cm_hi_t [STREAMS-1:0]          cm_hi;

    tsi_timing #(.CLK_PER_BIT(CLK_PER_BIT), .BITS(BITS), .CHANS(CHANS)) timing_i (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .ch_o(ch), .fmod_o(fmod),
        .bit_end_o(bit_end), .slot_end_o(slot_end)
    );

    tsi_capture #(.STREAMS(STREAMS), .CHANS(CHANS), .BITS(BITS)) capture_i (
        .clk(clk), .rst_n(rst_n), .sti_i(sti), .bit_end_i(bit_end),
        .slot_end_i(slot_end), .ch_i(ch), .fmod_i(fmod), .rd_bank_i(rd_bank),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .byte_now_o(byte_now)
    );

    tsi_connmem #(.STREAMS(STREAMS), .CHANS(CHANS), .LO_W(LO_W)) connmem_i (
        .clk(clk), .rst_n(rst_n), .we_i(cm_we), .sel_hi_i(cm_sel_hi),
        .addr_i(cm_addr), .wdata_i(cm_wdata), .rd_ch_i(k_next),
        .lo_o(cm_lo), .hi_o(cm_hi)
    );

    tsi_output #(.STREAMS(STREAMS), .CHANS(CHANS), .BITS(BITS), .LO_W(LO_W)) output_i (
        .clk(clk), .rst_n(rst_n), .ode_i(ode), .bit_end_i(bit_end),
        .slot_end_i(slot_end), .ch_i(ch), .fmod_i(fmod), .lo_i(cm_lo),
        .hi_i(cm_hi), .byte_now_i(byte_now), .rd_data_i(rd_data),
        .rd_bank_o(rd_bank), .rd_addr_o(rd_addr), .k_next_o(k_next),
        .sto_o(sto), .sto_oe_o(sto_oe), .ctl_o(ctl_o)
    );

endmodule

// File: tb/tdm_slot_switch_tb_top.sv
module tdm_slot_switch_tb_top;

    localparam int STREAMS = 4;
    localparam int CHANS   = 8;
    localparam int BITS    = 8;
    localparam int CPB     = 2;
    localparam int CH_W    = 3;
    localparam int ADDR_W  = 5;
    localparam int LO_W    = 8;
    localparam int SLOT_CYC  = BITS * CPB;
    localparam int FRAME_CYC = CHANS * SLOT_CYC;
    localparam int NF        = 48;
    localparam int EPOCH     = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n, fsync, ode;
    logic [STREAMS-1:0] sti, sto, sto_oe;
    logic               ctl_o;
    logic               cm_we, cm_sel_hi;
    logic [ADDR_W-1:0]  cm_addr;
    logic [LO_W-1:0]    cm_wdata;

    tdm_slot_switch #(.STREAMS(STREAMS), .CHANS(CHANS), .BITS(BITS), .CLK_PER_BIT(CPB)) dut_i (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .ode(ode), .sti(sti), .sto(sto),
        .sto_oe(sto_oe), .ctl_o(ctl_o), .cm_we(cm_we), .cm_sel_hi(cm_sel_hi),
        .cm_addr(cm_addr), .cm_wdata(cm_wdata)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [7:0] hist  [NF][STREAMS][CHANS];
    logic [7:0] m_lo  [STREAMS][CHANS];
    logic [3:0] m_hi  [STREAMS][CHANS];
    logic [7:0] n_lo  [STREAMS][CHANS];
    logic [3:0] n_hi  [STREAMS][CHANS];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Expected byte in output slot k of stream s during frame fr.
    function automatic logic [7:0] exp_byte(input int fr, input int s, input int k);
        logic [7:0] lo;
        logic [3:0] hi;
        int ss, sc;
        lo = m_lo[s][k];
        hi = m_hi[s][k];
        ss = int'(lo[ADDR_W-1:CH_W]);
        sc = int'(lo[CH_W-1:0]);
        if (hi[1]) return lo;                    // R5 message byte
        if (hi[2]) return hist[fr-2][ss][sc];    // R4 two frames later
        if (sc < k) return hist[fr][ss][sc];     // R3 same frame
        return hist[fr-1][ss][sc];               // R3 previous frame
    endfunction

    function automatic string req_of(input int s, input int k, input logic o);
        if (!o)             return "R7";
        if (!m_hi[s][k][0]) return "R6";
        if (m_hi[s][k][1])  return "R5";
        if (m_hi[s][k][2])  return "R2 R4 R10";
        return "R2 R3 R10";
    endfunction

    task automatic new_config(input int ep);
        for (int s = 0; s < STREAMS; s++) begin
            for (int k = 0; k < CHANS; k++) begin
                n_lo[s][k] = 8'($urandom);
                n_hi[s][k] = {1'($urandom), 1'($urandom), ($urandom % 8) == 0,
                              ($urandom % 8) != 0};
            end
        end
        if (ep == 0) begin
            n_lo[0][3] = 8'((1 << CH_W) | 2);     n_hi[0][3] = 4'b0001; // source slot k-1
            n_lo[1][3] = 8'((2 << CH_W) | 3);     n_hi[1][3] = 4'b1001; // same slot
            n_lo[2][0] = 8'((3 << CH_W) | 7);     n_hi[2][0] = 4'b0001; // last slot into slot 0
            n_lo[3][5] = 8'((0 << CH_W) | 6);     n_hi[3][5] = 4'b0101; // constant delay
            n_lo[0][0] = 8'hA5;                   n_hi[0][0] = 4'b0011; // message
            n_lo[1][6] = 8'h00;                   n_hi[1][6] = 4'b1000; // undriven, ctl set
            n_lo[2][7] = 8'hE0 | 8'((1 << CH_W) | 0); n_hi[2][7] = 4'b0001; // ignored high bits
        end
    endtask

    initial begin
        void'($urandom(32'h1D5C_7A01));
        rst_n = 1'b0; fsync = 1'b0; ode = 1'b0; sti = '0;
        cm_we = 1'b0; cm_sel_hi = 1'b0; cm_addr = '0; cm_wdata = '0;
        for (int f = 0; f < NF; f++)
            for (int s = 0; s < STREAMS; s++)
                for (int c = 0; c < CHANS; c++)
                    hist[f][s][c] = 8'($urandom);
        for (int s = 0; s < STREAMS; s++)
            for (int k = 0; k < CHANS; k++) begin
                m_lo[s][k] = '0; m_hi[s][k] = '0;
            end

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        ode = 1'b1;
        @(negedge clk);
        chk("R9 oe", 32'(sto_oe), 32'h0);
        chk("R9 sto", 32'(sto), 32'h0);
        chk("R9 ctl", 32'(ctl_o), 32'h0);
        fsync = 1'b1;

        for (int fr = 0; fr < NF; fr++) begin
            bit cfg_frame;
            bit checking;
            cfg_frame = (fr % EPOCH) == 0;
            checking  = (fr >= 3) && !cfg_frame;
            if (cfg_frame) new_config(fr / EPOCH);
            for (int p = 0; p < FRAME_CYC; p++) begin
                int c, b;
                @(negedge clk);
                fsync = 1'b0;
                c = p / SLOT_CYC;
                b = (p / CPB) % BITS;
                if (cfg_frame && p == 0) ode = ((fr / EPOCH) != 3);
                for (int s = 0; s < STREAMS; s++) sti[s] = hist[fr][s][c][BITS-1-b];
                // R10: one connection-memory write per cycle, low then high word
                if (cfg_frame && p < 2 * STREAMS * CHANS) begin
                    int e, es, ek;
                    e  = p / 2;
                    es = e / CHANS;
                    ek = e % CHANS;
                    cm_we     = 1'b1;
                    cm_sel_hi = p[0];
                    cm_addr   = ADDR_W'((es << CH_W) | ek);
                    cm_wdata  = p[0] ? {4'h0, n_hi[es][ek]} : n_lo[es][ek];
                end else begin
                    cm_we = 1'b0;
                end
                // R1: sample once per bit period, mid-way through its first cycle
                if (checking && (p % CPB) == 0) begin
                    for (int s = 0; s < STREAMS; s++) begin
                        logic eo;
                        logic [7:0] eb;
                        eo = ode & m_hi[s][c][0];
                        eb = exp_byte(fr, s, c);
                        chk(req_of(s, c, ode), {30'h0, sto_oe[s], sto[s]},
                            {30'h0, eo, eo & eb[BITS-1-b]});
                    end
                    chk("R8 ctl", 32'(ctl_o), (b < STREAMS) ? 32'(m_hi[b][c][3]) : 32'h0);
                end
            end
            if (cfg_frame) begin
                for (int s = 0; s < STREAMS; s++)
                    for (int k = 0; k < CHANS; k++) begin
                        m_lo[s][k] = n_lo[s][k];
                        m_hi[s][k] = n_hi[s][k];
                    end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule